// File: doc/BRIEF.md
# Memory Bus Turnaround Inserter

This block sits in a static memory controller between the access sequencer and the chip-select logic of the external bus. The sequencer raises a request with the bank number and direction of its next external access. The block compares that access with the last one that actually started. If the external data bus has to change hands, it holds the sequencer off with a stall for a programmable number of idle cycles. It then issues a one-cycle go pulse, which marks the cycle in which the chip select for the new access may be asserted.

A gap is needed when a read is followed by a write, to any bank. It is also needed when a write is followed by any access to a different bank. Reads after reads need no gap, and neither does any access to the bank that was just written. The gap length comes from a 5-bit setting, where value N gives N+1 idle cycles. The block takes this value in the cycle the request arrives. The sequencer holds its request until it sees the go pulse. It may withdraw the request during a gap.

Top module: `mem_turnaround_gate`

## Requirements
- R1: After reset no previous access exists. stall_o and go_o are low while req_i is low, and the first request after reset is granted with go_o in its own cycle and no stall.
- R2: A read (req_write_i = 0) that follows a read, to the same or to a different bank, gets no idle cycles.
- R3: A write (req_write_i = 1) that follows a read gets idle cycles, whether the bank is the same or different.
- R4: A write or a read that follows a write to the same bank (equal req_bank_i binary value) gets no idle cycles.
- R5: Any access that follows a write to a different bank gets idle cycles.
- R6: With gap_cfg_i = N, a request that needs a gap sees stall_o high for exactly N+1 cycles, starting with its own first cycle, and go_o in the cycle right after the last of them. The range is 1 cycle for N = 0 up to 32 cycles for N = 31.
- R7: The gap length is taken from gap_cfg_i in the first cycle of the request. Changes to gap_cfg_i during the gap have no effect on its length.
- R8: The remembered bank and direction change only in a cycle with go_o high. A request withdrawn during a gap gets no go_o, drops stall_o in the next cycle and leaves the remembered access unchanged.
- R9: go_o and stall_o are never high together, and go_o is only high while req_i is high.
- R10: A request that needs no gap gets go_o in the same cycle it is first presented, with stall_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Access request, held until go_o |
| req_bank_i | input | BANK_W | Bank number of the requested access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| gap_cfg_i | input | CNT_W | Turnaround setting N, giving N+1 idle cycles |
| stall_o | output | 1 | Hold-off to the sequencer during idle cycles |
| go_o | output | 1 | One-cycle pulse: the access may start |

## Verification
The bench uses the default parameters: BANK_W = 2, which gives four banks, and CNT_W = 5. With four banks, every same-bank and different-bank pairing in both directions can be reached in one sequence. The 5-bit setting lets the bench cover both ends of the gap range, a single idle cycle and thirty-two. Together these make the exact stall count and the cycle of the go pulse observable at every boundary.

// File: rtl/tat_pkg.sv
package tat_pkg;

  // Phase of the gating sequencer
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_GAP  = 1'b1
  } tat_phase_e;

endpackage

// File: rtl/tat_history.sv
module tat_history #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              write_i,
  output logic              valid_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              write_o
);

  logic              valid_q, valid_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              write_q, write_d;

  always_comb begin
    valid_d = valid_q;
    bank_d  = bank_q;
    write_d = write_q;
    if (capture_i) begin
      valid_d = 1'b1;
      bank_d  = bank_i;
      write_d = write_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bank_q  <= '0;
      write_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      bank_q  <= bank_d;
      write_q <= write_d;
    end
  end

  assign valid_o = valid_q;
  assign bank_o  = bank_q;
  assign write_o = write_q;

  // R8
  hist_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> (valid_o && bank_o == $past(bank_i) && write_o == $past(write_i)));

  // R8
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> ($stable(bank_o) && $stable(write_o) && $stable(valid_o)));

endmodule

// File: rtl/tat_decide.sv
module tat_decide #(
  parameter int BANK_W = 2
) (
  input  logic              prev_valid_i,
  input  logic [BANK_W-1:0] prev_bank_i,
  input  logic              prev_write_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              write_i,
  output logic              need_gap_o
);

  logic bank_change;
  logic rd_to_wr;
  logic wr_to_other;

  always_comb begin
    bank_change = (bank_i != prev_bank_i);
    rd_to_wr    = !prev_write_i && write_i;
    wr_to_other = prev_write_i && bank_change;
    need_gap_o  = prev_valid_i && (rd_to_wr || wr_to_other);
  end

endmodule

// File: rtl/tat_gap_counter.sv
module tat_gap_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (dec_i && (cnt_q != '0));
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !zero_o) |=> (cnt_o == $past(cnt_o) - 1'b1));

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == $past(load_val_i)));

endmodule

// File: rtl/mem_turnaround_gate.sv
module mem_turnaround_gate #(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic              req_write_i,
  input  logic [CNT_W-1:0]  gap_cfg_i,
  output logic              stall_o,
  output logic              go_o
);

  import tat_pkg::*;

  tat_phase_e        phase_q, phase_d;
  logic              prev_valid;
  logic [BANK_W-1:0] prev_bank;
  logic              prev_write;
  logic              need_gap;
  logic              cnt_load;
  logic              cnt_dec;
  logic [CNT_W-1:0]  cnt_val;
  logic              cnt_zero;
  logic              go_c;
  logic              stall_c;

  tat_history #(.BANK_W(BANK_W)) i_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (go_c),
    .bank_i    (req_bank_i),
    .write_i   (req_write_i),
    .valid_o   (prev_valid),
    .bank_o    (prev_bank),
    .write_o   (prev_write)
  );

  tat_decide #(.BANK_W(BANK_W)) i_decide (
    .prev_valid_i (prev_valid),
    .prev_bank_i  (prev_bank),
    .prev_write_i (prev_write),
    .bank_i       (req_bank_i),
    .write_i      (req_write_i),
    .need_gap_o   (need_gap)
  );

  tat_gap_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (gap_cfg_i),
    .dec_i      (cnt_dec),
    .cnt_o      (cnt_val),
    .zero_o     (cnt_zero)
  );

  // Next-state and output decode
  always_comb begin
    phase_d  = phase_q;
    go_c     = 1'b0;
    stall_c  = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          if (need_gap) begin
            stall_c  = 1'b1;
            cnt_load = 1'b1;
            phase_d  = PH_GAP;
          end else begin
            go_c = 1'b1;
          end
        end
      end
      PH_GAP: begin
        if (!req_i) begin
          phase_d = PH_IDLE;
        end else if (cnt_zero) begin
          go_c    = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          stall_c = 1'b1;
          cnt_dec = 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign go_o    = go_c;
  assign stall_o = stall_c;

  // R9
  go_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_o && stall_o));

  // R9
  go_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> req_i);

  // R1
  first_access_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_valid && phase_q == PH_IDLE && req_i) |-> (go_o && !stall_o));

  // R4
  same_bank_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE && req_i && prev_valid && prev_write && prev_bank == req_bank_i)
      |-> !stall_o);

  // R8
  withdraw_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_GAP && !req_i) |=> (phase_q == PH_IDLE));

endmodule

// File: tb/test_mem_turnaround_gate.sv
module test_mem_turnaround_gate;

  localparam int BANK_W = 2;
  localparam int CNT_W  = 5;
  localparam int NVEC   = 13;

  logic              clk;
  logic              rst_n;
  logic              req_i;
  logic [BANK_W-1:0] req_bank_i;
  logic              req_write_i;
  logic [CNT_W-1:0]  gap_cfg_i;
  logic              stall_o;
  logic              go_o;

  int checks;
  int errors;

  // {bank[1:0], write, cfg[4:0], expected stall cycles[5:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 5'd3,  6'd0},   // R1 first access
    {2'd1, 1'b0, 5'd3,  6'd0},   // R2 read->read other bank
    {2'd1, 1'b1, 5'd3,  6'd4},   // R3 read->write same bank
    {2'd1, 1'b1, 5'd0,  6'd0},   // R4 write->write same bank
    {2'd1, 1'b0, 5'd7,  6'd0},   // R4 write->read same bank
    {2'd2, 1'b1, 5'd2,  6'd3},   // R3 read->write other bank
    {2'd3, 1'b1, 5'd0,  6'd1},   // R5 R6 write->write other, minimum
    {2'd0, 1'b0, 5'd31, 6'd32},  // R5 R6 write->read other, maximum
    {2'd0, 1'b0, 5'd5,  6'd0},   // R2 read->read same bank
    {2'd3, 1'b0, 5'd1,  6'd0},   // R2 read->read other bank
    {2'd3, 1'b1, 5'd1,  6'd2},   // R3 read->write same bank
    {2'd0, 1'b1, 5'd4,  6'd5},   // R5 write->write other bank
    {2'd0, 1'b0, 5'd9,  6'd0}    // R4 write->read same bank
  };

  mem_turnaround_gate #(.BANK_W(BANK_W), .CNT_W(CNT_W)) i_mem_turnaround_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .req_bank_i  (req_bank_i),
    .req_write_i (req_write_i),
    .gap_cfg_i   (gap_cfg_i),
    .stall_o     (stall_o),
    .go_o        (go_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present a request and measure stall cycles and the go cycle.
  // change_at >= 0 rewrites gap_cfg_i to new_cfg after that many cycles.
  task automatic access(input string req, input int bank, input bit wr, input int cfg,
                        input int exp_stall, input int change_at, input int new_cfg);
    int stalls;
    int cyc;
    int both;
    stalls = 0;
    cyc    = 0;
    both   = 0;
    @(negedge clk);
    req_i       = 1'b1;
    req_bank_i  = BANK_W'(bank);
    req_write_i = wr;
    gap_cfg_i   = CNT_W'(cfg);
    #1;
    while (!go_o && cyc < 100) begin
      if (stall_o) stalls++;
      @(negedge clk);
      cyc++;
      if (cyc == change_at) gap_cfg_i = CNT_W'(new_cfg);
      #1;
    end
    if (go_o && stall_o) both = 1;
    check({req, " stall cycles"}, stalls, exp_stall);
    check({req, " go cycle"}, cyc, exp_stall);
    check("R9 go without stall", both, 0);
    @(negedge clk);
    req_i = 1'b0;
    #1;
    check("R9 no go after req drop", int'(go_o), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_i = 1'b0;
    #1;
    check("R1 stall low in reset", int'(stall_o), 0);
    check("R1 go low in reset", int'(go_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    checks      = 0;
    errors      = 0;
    rst_n       = 1'b0;
    req_i       = 1'b0;
    req_bank_i  = '0;
    req_write_i = 1'b0;
    gap_cfg_i   = '0;
    repeat (3) @(negedge clk);
    do_reset();
    @(negedge clk);
    #1;
    check("R1 idle stall after reset", int'(stall_o), 0);
    check("R1 idle go after reset", int'(go_o), 0);

    // Table walk: R1..R6, R10
    for (int i = 0; i < NVEC; i++) begin
      access($sformatf("R10 vec%0d", i), int'(VEC[i][13:12]), VEC[i][11],
             int'(VEC[i][10:6]), int'(VEC[i][5:0]), -1, 0);
    end

    // R7: previous is bank0 read; write bank0, cfg 2 then changed to 20
    access("R7 cfg change ignored", 0, 1'b1, 2, 3, 1, 20);

    // R8: previous is bank0 write; read bank1 would need gap, withdraw it
    @(negedge clk);
    req_i       = 1'b1;
    req_bank_i  = 2'd1;
    req_write_i = 1'b0;
    gap_cfg_i   = 5'd6;
    #1;
    check("R8 withdraw candidate stalls", int'(stall_o), 1);
    @(negedge clk);
    #1;
    check("R8 still stalling", int'(stall_o), 1);
    @(negedge clk);
    req_i = 1'b0;
    #1;
    check("R8 go absent on withdraw", int'(go_o), 0);
    @(negedge clk);
    #1;
    check("R8 stall drops after withdraw", int'(stall_o), 0);
    check("R8 no late go", int'(go_o), 0);
    // history must still be bank0 write: write bank0 needs no gap
    access("R8 history kept", 0, 1'b1, 6, 0, -1, 0);

    // R1: reset clears history; write bank2 after bank0 write goes at once
    do_reset();
    access("R1 first after reset", 2, 1'b1, 4, 0, -1, 0);
    // and now read bank2 after it: R4 same-bank, no gap
    access("R4 after reset pair", 2, 1'b0, 4, 0, -1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule